// File: doc/BRIEF.md
# Pretrigger / Posttrigger Capture Sequencer

This block runs a triggered acquisition that keeps a window of history around a reference event. Once armed, it waits for a rising edge on the start trigger. It then waits a programmed number of clock cycles. After that it turns each sample strobe into a write into a circular buffer. The buffer depth is the sum of the programmed pretrigger and posttrigger counts, so the write address wraps back to zero after address `preCount+postCount-1`.

A rising edge on the reference trigger is honoured only after at least `preCount` samples have been written. An earlier edge is dropped. Once the trigger is accepted, the block writes exactly `postCount` more samples, pulses `done` and returns to idle. It latches the address of the first posttrigger slot so a reader can unwrap the buffer. The pretrigger data are the `preCount` slots just before that address, and the posttrigger data start at it.

The programmed counts and the delay must stay stable from arming until `done`. Their sum must lie between 1 and `DEPTH`. The sample strobe comes from the same clock as the block.

Top module: `refTrigCtrl`

## Requirements
- R1: After reset `wrEn`, `done` and `trigAddr` are 0, and the block is idle. In idle, sample strobes and trigger edges produce no write and no `done`.
- R2: A one-cycle `arm` pulse in idle makes the block wait for a start trigger. A start-trigger rising edge seen while idle (not armed) is ignored.
- R3: After the cycle in which the start edge is seen, sample strobes are ignored for `startDelay+1` cycles. The first strobe after that writes to address 0.
- R4: Every strobe accepted during the acquisition raises `wrEn` for exactly the next cycle, with `wrAddr` set to the write address. Addresses step by one and wrap from `preCount+postCount-1` to 0.
- R5: A reference-trigger rising edge in a cycle where fewer than `preCount` samples have been written (counting strobes of earlier cycles only) is ignored.
- R6: When the reference edge is accepted, `trigAddr` takes the address the next sample will be written to, and holds it until the next accepted trigger.
- R7: After an accepted trigger exactly `postCount` further strobes are written. `done` is high in the same cycle as the last of these writes, and later strobes are ignored.
- R8: With `postCount` = 0, `done` is high in the cycle after the accepted reference edge, and no further write occurs.
- R9: Triggers are edge-detected. A reference trigger held high does not count again once the pretrigger quota fills. Only one reference trigger is accepted per acquisition.
- R10: `done` lasts one cycle, and the block is then idle until it is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the sample timebase |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm pulse, honoured only in idle |
| startTrig | input | 1 | Start trigger level, rising edge used |
| refTrig | input | 1 | Reference trigger level, rising edge used |
| sampleStrobe | input | 1 | One-cycle pulse per sample |
| preCount | input | $clog2(DEPTH+1) | Pretrigger samples required |
| postCount | input | $clog2(DEPTH+1) | Posttrigger samples to write |
| startDelay | input | DLYW | Cycles between start edge and sampling |
| wrEn | output | 1 | Buffer write enable |
| wrAddr | output | $clog2(DEPTH) | Circular write address |
| trigAddr | output | $clog2(DEPTH) | First posttrigger address |
| done | output | 1 | Capture complete pulse |

## Verification
The bench fires a strobe in the last cycle of the start delay. A sequencer whose delay is off by one would write that sample. It sends reference edges one sample short of the pretrigger quota, then holds the trigger high across the point where the quota fills. A design that qualified by level, or by a count that already includes the current strobe, would trigger early. Captures are run with a short post count that wraps the address, with a post count of zero, and with a pretrigger count of zero. A wrong wrap point, a miscounted tail, or a `done` for a zero-length tail in the wrong cycle shows up as a mismatched address or flag. Strobes after `done`, and a second reference edge during the tail, must produce no activity.

// File: rtl/refTrigPkg.sv
package refTrigPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_DELAY, ST_PRE, ST_POST
  } acqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRun;
    logic loadDelay;
    logic decDelay;
    logic writeSample;
    logic latchTrig;
    logic decPost;
    logic finish;
  } pathCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic delayZero;
    logic preFull;
    logic postLast;
    logic postZero;
  } pathStat_t;
endpackage

// File: rtl/refTrigPath.sv
module refTrigPath
  import refTrigPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLYW  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  pathCtl_t        ctl,
  input  logic [CW-1:0]   preCount,
  input  logic [CW-1:0]   postCount,
  input  logic [DLYW-1:0] startDelay,
  output pathStat_t       stat,
  output logic            wrEn,
  output logic [AW-1:0]   wrAddr,
  output logic [AW-1:0]   trigAddr,
  output logic            done
);
  localparam int SW = CW + 1;

  logic [AW-1:0]   ptr, ptrNext;
  logic [CW-1:0]   preTaken, postLeft;
  logic [DLYW-1:0] dlyCnt;
  logic [SW-1:0]   lastSlot;
  logic            atEnd;

  // last valid slot of the circular region
  assign lastSlot = SW'(preCount) + SW'(postCount) - SW'(1);
  assign atEnd    = (SW'(ptr) == lastSlot);
  assign ptrNext  = atEnd ? '0 : ptr + AW'(1);

  assign stat.delayZero = (dlyCnt == '0);
  assign stat.preFull   = (preTaken >= preCount);
  assign stat.postLast  = (postLeft == CW'(1));
  assign stat.postZero  = (postCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      preTaken <= '0;
      postLeft <= '0;
      dlyCnt   <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      trigAddr <= '0;
      done     <= 1'b0;
    end else begin
      wrEn <= ctl.writeSample;
      done <= ctl.finish;
      if (ctl.loadDelay)      dlyCnt <= startDelay;
      else if (ctl.decDelay)  dlyCnt <= dlyCnt - DLYW'(1);
      if (ctl.clearRun) begin
        ptr      <= '0;
        preTaken <= '0;
      end else if (ctl.writeSample) begin
        ptr    <= ptrNext;
        wrAddr <= ptr;
        if (!stat.preFull) preTaken <= preTaken + CW'(1);
      end
      if (ctl.latchTrig) begin
        trigAddr <= ctl.writeSample ? ptrNext : ptr;
        postLeft <= postCount;
      end else if (ctl.decPost) begin
        postLeft <= postLeft - CW'(1);
      end
    end
  end
endmodule

// File: rtl/refTrigFsm.sv
module refTrigFsm
  import refTrigPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      arm,
  input  logic      startTrig,
  input  logic      refTrig,
  input  logic      sampleStrobe,
  input  pathStat_t stat,
  output pathCtl_t  ctl,
  output acqState_e state
);
  localparam int NTRIG = 2;

  logic [NTRIG-1:0] trigIn, trigPrev, trigEdge;
  acqState_e        stateNext;

  assign trigIn = {refTrig, startTrig};

  // rising-edge detector per trigger input
  for (genvar g = 0; g < NTRIG; g++) begin : gEdge
    always_ff @(posedge clk) begin
      if (!rstN) trigPrev[g] <= 1'b0;
      else       trigPrev[g] <= trigIn[g];
    end
    assign trigEdge[g] = trigIn[g] & ~trigPrev[g];
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (arm) stateNext = ST_ARMED;
      ST_ARMED: if (trigEdge[0]) begin
        ctl.loadDelay = 1'b1;
        ctl.clearRun  = 1'b1;
        stateNext     = ST_DELAY;
      end
      ST_DELAY: begin
        if (stat.delayZero) stateNext = ST_PRE;
        else                ctl.decDelay = 1'b1;
      end
      ST_PRE: begin
        ctl.writeSample = sampleStrobe;
        if (trigEdge[1] && stat.preFull) begin
          ctl.latchTrig = 1'b1;
          if (stat.postZero) begin
            ctl.finish = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            stateNext  = ST_POST;
          end
        end
      end
      ST_POST: if (sampleStrobe) begin
        ctl.writeSample = 1'b1;
        ctl.decPost     = 1'b1;
        if (stat.postLast) begin
          ctl.finish = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/refTrigCtrl.sv
module refTrigCtrl
  import refTrigPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLYW  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            arm,
  input  logic            startTrig,
  input  logic            refTrig,
  input  logic            sampleStrobe,
  input  logic [CW-1:0]   preCount,
  input  logic [CW-1:0]   postCount,
  input  logic [DLYW-1:0] startDelay,
  output logic            wrEn,
  output logic [AW-1:0]   wrAddr,
  output logic [AW-1:0]   trigAddr,
  output logic            done
);
  pathCtl_t  ctl;
  pathStat_t stat;
  acqState_e state;

  refTrigFsm u_fsm (
    .clk, .rstN, .arm, .startTrig, .refTrig, .sampleStrobe,
    .stat, .ctl, .state
  );

  refTrigPath #(.DEPTH(DEPTH), .DLYW(DLYW)) u_path (
    .clk, .rstN, .ctl, .preCount, .postCount, .startDelay,
    .stat, .wrEn, .wrAddr, .trigAddr, .done
  );
endmodule

// File: rtl/refTrigCtrl_chk.sv
module refTrigCtrl_chk
  import refTrigPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          sampleStrobe,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic          done,
  input logic [CW-1:0] preCount,
  input logic [CW-1:0] postCount,
  input acqState_e     state,
  input logic          preFull
);
  assert_write_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(sampleStrobe));

  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ((CW+1)'(wrAddr) < (CW+1)'(preCount) + (CW+1)'(postCount)));

  assert_no_write_before_sampling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_ARMED || state == ST_DELAY) |=> !wrEn);

  assert_early_ref_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && !preFull) |=> state == ST_PRE);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> state == ST_IDLE);
endmodule

bind refTrigCtrl refTrigCtrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .wrEn(wrEn),
  .wrAddr(wrAddr), .done(done), .preCount(preCount), .postCount(postCount),
  .state(state), .preFull(stat.preFull)
);

// File: tb/refTrigCtrl_tb.sv
module refTrigCtrl_tb;
  localparam int DEPTH = 16;
  localparam int DLYW  = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 1'b0, startTrig = 1'b0, refTrig = 1'b0, sampleStrobe = 1'b0;
  logic [CW-1:0] preCount = '0, postCount = '0;
  logic [DLYW-1:0] startDelay = '0;
  logic wrEn, done;
  logic [AW-1:0] wrAddr, trigAddr;

  always #10 clk = ~clk;

  refTrigCtrl #(.DEPTH(DEPTH), .DLYW(DLYW)) u_dut (
    .clk, .rstN, .arm, .startTrig, .refTrig, .sampleStrobe,
    .preCount, .postCount, .startDelay,
    .wrEn, .wrAddr, .trigAddr, .done
  );

  typedef struct {
    bit    isWrite;
    int    addr;
    bit    isDone;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecked = 0, nFailed = 0;
  bit  finished = 0;
  int  mPre, mPost, mPtr, mTaken, mPhase, mLeft, mTrig;

  task automatic check(string req, int act, int exp);
    nChecked++;
    if (act != exp) begin
      nFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every write or done must match the next expected item
  always @(negedge clk) begin
    if (rstN && (wrEn || done)) begin
      if (expQ.size() == 0) begin
        nChecked++; nFailed++;
        $display("FAIL R1/R7 unexpected output: actual wrEn=%0d addr=%0d done=%0d expected none",
                 wrEn, wrAddr, done);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.req, " write flag"}, int'(wrEn), int'(it.isWrite));
        if (it.isWrite) check({it.req, " address"}, int'(wrAddr), it.addr);
        check({it.req, " done flag"}, int'(done), int'(it.isDone));
      end
    end
  end

  function automatic int nextPtr(int p);
    return (p + 1 == mPre + mPost) ? 0 : p + 1;
  endfunction

  task automatic doArm();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  // start edge, plus one strobe in the last delay cycle (R3: must be ignored)
  task automatic doStart(int dly);
    startTrig = 1'b1; @(negedge clk); startTrig = 1'b0;
    repeat (dly) @(negedge clk);
    sampleStrobe = 1'b1; @(negedge clk); sampleStrobe = 1'b0;
    mPhase = 1; mPtr = 0; mTaken = 0;
  endtask

  task automatic setup(int pre, int post, int dly);
    mPre = pre; mPost = post;
    preCount = CW'(pre); postCount = CW'(post); startDelay = DLYW'(dly);
    doArm();
    doStart(dly);
  endtask

  task automatic sample(string req);
    expItem_t it;
    sampleStrobe = 1'b1;
    if (mPhase == 1) begin
      it = '{1, mPtr, 0, req};
      expQ.push_back(it);
      mTaken++; mPtr = nextPtr(mPtr);
    end else if (mPhase == 2) begin
      it = '{1, mPtr, (mLeft == 1), req};
      expQ.push_back(it);
      mPtr = nextPtr(mPtr); mLeft--;
      if (mLeft == 0) mPhase = 0;
    end
    @(negedge clk); sampleStrobe = 1'b0;
  endtask

  function automatic void refModel();
    expItem_t it;
    if (mPhase == 1 && mTaken >= mPre) begin
      mTrig = mPtr;
      if (mPost == 0) begin
        it = '{0, 0, 1, "R8"};
        expQ.push_back(it);
        mPhase = 0;
      end else begin
        mPhase = 2; mLeft = mPost;
      end
    end
  endfunction

  task automatic refPulse();
    refTrig = 1'b1; refModel(); @(negedge clk); refTrig = 1'b0; @(negedge clk);
  endtask

  task automatic drain(string req);
    repeat (3) @(negedge clk);
    check({req, " pending expected outputs"}, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecked++; nFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    mPhase = 0; mPre = 1; mPost = 1; mTrig = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 wrEn after reset", int'(wrEn), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 trigAddr after reset", int'(trigAddr), 0);
    // R1/R2: idle strobes, start and ref edges without arm do nothing
    preCount = 5'd2; postCount = 5'd2;
    sampleStrobe = 1'b1; @(negedge clk); sampleStrobe = 1'b0;
    startTrig = 1'b1; @(negedge clk); startTrig = 1'b0;
    repeat (3) begin sampleStrobe = 1'b1; @(negedge clk); sampleStrobe = 1'b0; @(negedge clk); end
    refTrig = 1'b1; @(negedge clk); refTrig = 1'b0;
    sampleStrobe = 1'b1; @(negedge clk); sampleStrobe = 1'b0;
    drain("R2 unarmed start ignored");
    check("R2 trigAddr untouched", int'(trigAddr), 0);

    // R3/R4/R6/R7: pre 3, post 4, delay 2, wrap at 7
    setup(3, 4, 2);
    for (int i = 0; i < 5; i++) sample("R4 pretrigger write");
    refPulse();
    check("R6 trigAddr at first post slot", int'(trigAddr), 5);
    for (int i = 0; i < 4; i++) sample("R7 posttrigger write with wrap");
    sample("R7 strobe after done ignored");
    drain("R7 capture tail");
    check("R6 trigAddr held after done", int'(trigAddr), mTrig);

    // R5/R9: early ref ignored, second ref ignored in tail
    setup(4, 2, 0);
    sample("R4 pre"); sample("R4 pre");
    refPulse();
    sample("R5 pre after early ref");
    refPulse();
    sample("R5 pre after early ref");
    check("R5 trigAddr unchanged by early ref", int'(trigAddr), 5);
    refPulse();
    check("R6 trigAddr after accept", int'(trigAddr), 4);
    sample("R7 post");
    refPulse();
    sample("R9 post after second ref");
    sample("R10 idle after done");
    drain("R9 single trigger");

    // R9: ref held high across quota fill does not count
    setup(2, 3, 1);
    sample("R4 pre");
    refTrig = 1'b1; refModel(); @(negedge clk);
    for (int i = 0; i < 4; i++) sample("R9 pre while ref held");
    refTrig = 1'b0; @(negedge clk);
    check("R9 held level gave no trigger", int'(trigAddr), 4);
    refPulse();
    check("R6 trigAddr after wrapped pre", int'(trigAddr), 0);
    for (int i = 0; i < 3; i++) sample("R7 post");
    drain("R9 held level");

    // R8: post count zero completes on the trigger
    setup(2, 0, 3);
    for (int i = 0; i < 3; i++) sample("R4 pre");
    refPulse();
    check("R8 trigAddr", int'(trigAddr), 1);
    sample("R8 strobe after zero-tail done");
    drain("R8 zero tail");

    // R10: no re-arm means no activity; then pre 0 accepts at once
    startTrig = 1'b1; @(negedge clk); startTrig = 1'b0;
    sampleStrobe = 1'b1; @(negedge clk); sampleStrobe = 1'b0;
    drain("R10 needs re-arm");
    setup(0, 2, 0);
    refPulse();
    check("R6 trigAddr with zero pre", int'(trigAddr), 0);
    sample("R7 post"); sample("R7 post");
    drain("R7 zero pre");

    finishRun();
  end
endmodule